// File: doc/BRIEF.md
# Latency-Configurable Dual-Port Memory Wrapper

This block wraps a small word memory, which reads combinationally and writes on a clock edge, so that it shows a chosen read latency (zero or more cycles) and a chosen write latency (one or more cycles). The delay comes from pipelines placed on the request side, the response side, or both. A read-under-write policy parameter picks where the read delay sits. In read-first mode the array is read when the request arrives and the result is delayed. In write-first mode the request is delayed and the array is read at the end of the delay, so writes that land in the meantime are seen.

It has a dedicated read port, a dedicated write port and an optional shared port. The shared port carries a write-mode bit and is split inside into one read request and one write request. Each pipeline stage has a valid flag, which is reset, and a payload register, which loads only when the incoming flag is set. The read response pipeline is qualified by the valid of the final read request stage. All ports share one clock.

Top module: `lat_mem_wrap`

## Requirements
- R1: In read-first mode, a read accepted in cycle t returns the word as it was in cycle t, before any write committing at the end of cycle t, on the read data output in cycle t+RD_LAT.
- R2: In write-first mode, a read accepted in cycle t returns, in cycle t+RD_LAT, the word as it stands in cycle t+RD_LAT, including writes that committed after cycle t.
- R3: A write accepted in cycle t changes the array at the end of cycle t+WR_LAT-1, so a read of the array in cycle t+WR_LAT or later sees it. A read of the same address two accesses after the write follows R1/R2 with this timing.
- R4: A write request whose mask bit is 0 leaves the addressed word unchanged.
- R5: A shared port access with write-mode 1 is a write (mask from the shared mask bit). With write-mode 0 it is a read, and its data follows the same policy and latency as the read port.
- R6: In read-first mode with RD_LAT>0, a read data output keeps its last returned value in every cycle that carries no response.
- R7: With RD_LAT=0, read data is the word at the read address in the same cycle, whatever the read enable is, so the enable may be driven from the read data without a combinational loop.
- R8: When both write paths commit to the same address in the same cycle, the shared port's data is stored.
- R9: While reset is high, no request of any port enters a pipeline and the array is not written. Valid flags clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read result |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_mask | input | 1 | Write takes effect only when 1 |
| sh_en | input | 1 | Shared port request |
| sh_wmode | input | 1 | Shared port: 1 write, 0 read |
| sh_addr | input | ADDR_W | Shared port address |
| sh_wmask | input | 1 | Shared port write mask |
| sh_wdata | input | DATA_W | Shared port write data |
| sh_rdata | output | DATA_W | Shared port read result |

## Verification
A misplaced or miscounted stage shows up as read data arriving one cycle early or late. In a read-after-write hazard that also means the old word appears where the new one was due, or the reverse. A payload register that loads without its valid corrupts held read-first data in the first idle cycle. A valid flag that survives reset produces a write that was never legally requested, visible at the next read of that address. Three configurations (write-first with long latencies, read-first, and zero read latency) run the same stimulus, so a policy error diverges from the bench model within RD_LAT+WR_LAT cycles of the affected write.

// File: rtl/lat_mem_pkg.sv
`timescale 1ns/1ps
package lat_mem_pkg;

  typedef enum logic {
    RUW_READ_FIRST  = 1'b0,
    RUW_WRITE_FIRST = 1'b1
  } ruw_mode_e;

  // Number of read latency cycles spent before the array access.
  function automatic int cmd_depth(ruw_mode_e mode, int lat);
    return (mode == RUW_WRITE_FIRST) ? lat : 0;
  endfunction

endpackage

// File: rtl/lat_mem_vpipe.sv
`timescale 1ns/1ps
// Valid-qualified delay line: flags always shift, payload loads only with a set flag.
module lat_mem_vpipe #(
  parameter int DEPTH = 1,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  output logic         out_vld,
  output logic [W-1:0] out_data
);

  if (DEPTH == 0) begin : g_pass
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst;
    assign out_vld  = in_vld;
    assign out_data = in_data;
  end else begin : g_pipe
    for (genvar s = 0; s < DEPTH; s++) begin : g_st
      logic         prev_vld;
      logic [W-1:0] prev_data;
      logic         vld_q;
      logic [W-1:0] data_q;

      if (s == 0) begin : g_head
        assign prev_vld  = in_vld;
        assign prev_data = in_data;
      end else begin : g_body
        assign prev_vld  = g_st[s-1].vld_q;
        assign prev_data = g_st[s-1].data_q;
      end

      always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= prev_vld;
      end

      always_ff @(posedge clk) begin
        if (prev_vld) data_q <= prev_data;
      end
    end

    assign out_vld  = g_st[DEPTH-1].vld_q;
    assign out_data = g_st[DEPTH-1].data_q;
  end

endmodule

// File: rtl/lat_mem_core.sv
`timescale 1ns/1ps
// Word array: asynchronous read ports, clocked write ports; higher index wins a collision.
module lat_mem_core #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] we,
  input  logic [AW-1:0] wa [NP],
  input  logic [DW-1:0] wd [NP],
  input  logic [AW-1:0] ra [NP],
  output logic [DW-1:0] rd [NP]
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst) begin
      for (int p = 0; p < NP; p++) begin
        if (we[p]) mem[wa[p]] <= wd[p];
      end
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_rd
    assign rd[g] = mem[ra[g]];
  end

endmodule

// File: rtl/lat_mem_rd_chan.sv
`timescale 1ns/1ps
// One read channel: request pipeline before the array, response pipeline after it.
module lat_mem_rd_chan
  import lat_mem_pkg::*;
#(
  parameter ruw_mode_e RUW    = RUW_WRITE_FIRST,
  parameter int        RD_LAT = 1,
  parameter int        AW     = 4,
  parameter int        DW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_en,
  input  logic [AW-1:0] req_addr,
  output logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_data,
  output logic          rsp_vld,
  output logic [DW-1:0] rsp_data
);

  localparam int CMD_D = cmd_depth(RUW, RD_LAT);
  localparam int RSP_D = RD_LAT - CMD_D;

  logic cmd_vld;

  lat_mem_vpipe #(.DEPTH(CMD_D), .W(AW)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (req_en),
    .in_data  (req_addr),
    .out_vld  (cmd_vld),
    .out_data (arr_addr)
  );

  lat_mem_vpipe #(.DEPTH(RSP_D), .W(DW)) u_rsp (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (cmd_vld),
    .in_data  (arr_data),
    .out_vld  (rsp_vld),
    .out_data (rsp_data)
  );

endmodule

// File: rtl/lat_mem_wrap.sv
`timescale 1ns/1ps
module lat_mem_wrap
  import lat_mem_pkg::*;
#(
  parameter int        ADDR_W     = 4,
  parameter int        DATA_W     = 8,
  parameter int        RD_LAT     = 2,
  parameter int        WR_LAT     = 2,
  parameter ruw_mode_e RUW        = RUW_WRITE_FIRST,
  parameter bit        HAS_SHARED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mask,
  input  logic              sh_en,
  input  logic              sh_wmode,
  input  logic [ADDR_W-1:0] sh_addr,
  input  logic              sh_wmask,
  input  logic [DATA_W-1:0] sh_wdata,
  output logic [DATA_W-1:0] sh_rdata
);

  localparam int NP        = 2;
  localparam int WR_STAGES = WR_LAT - 1;
  localparam int WCMD_W    = ADDR_W + 1 + DATA_W;
  localparam int MASK_BIT  = DATA_W;

  logic [NP-1:0]     rreq, wreq, wvld_q, arr_we, rsp_vld;
  logic [ADDR_W-1:0] rreq_addr [NP];
  logic [ADDR_W-1:0] arr_ra    [NP];
  logic [ADDR_W-1:0] arr_wa    [NP];
  logic [DATA_W-1:0] arr_wd    [NP];
  logic [DATA_W-1:0] arr_rd    [NP];
  logic [DATA_W-1:0] rsp_data  [NP];
  logic [WCMD_W-1:0] wcmd      [NP];
  logic [WCMD_W-1:0] wcmd_q    [NP];
  logic              rd_rsp_vld, sh_rsp_vld;

  // Port 0: dedicated ports; requests are blocked while in reset.
  assign rreq[0]      = rd_en & ~rst;
  assign rreq_addr[0] = rd_addr;
  assign wreq[0]      = wr_en & ~rst;
  assign wcmd[0]      = {wr_addr, wr_mask, wr_data};

  // Port 1: shared port split by write mode.
  if (HAS_SHARED) begin : g_shared
    assign rreq[1]      = sh_en & ~sh_wmode & ~rst;
    assign wreq[1]      = sh_en &  sh_wmode & ~rst;
    assign rreq_addr[1] = sh_addr;
    assign wcmd[1]      = {sh_addr, sh_wmask, sh_wdata};
    assign sh_rdata     = rsp_data[1];
  end else begin : g_no_shared
    logic unused_sh;
    assign unused_sh    = ^{sh_en, sh_wmode, sh_addr, sh_wmask, sh_wdata, rsp_data[1]};
    assign rreq[1]      = 1'b0;
    assign wreq[1]      = 1'b0;
    assign rreq_addr[1] = '0;
    assign wcmd[1]      = '0;
    assign sh_rdata     = '0;
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    lat_mem_vpipe #(.DEPTH(WR_STAGES), .W(WCMD_W)) u_wpipe (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (wreq[p]),
      .in_data  (wcmd[p]),
      .out_vld  (wvld_q[p]),
      .out_data (wcmd_q[p])
    );

    assign arr_we[p] = wvld_q[p] & wcmd_q[p][MASK_BIT];
    assign arr_wa[p] = wcmd_q[p][WCMD_W-1 -: ADDR_W];
    assign arr_wd[p] = wcmd_q[p][DATA_W-1:0];

    lat_mem_rd_chan #(.RUW(RUW), .RD_LAT(RD_LAT), .AW(ADDR_W), .DW(DATA_W)) u_rd (
      .clk      (clk),
      .rst      (rst),
      .req_en   (rreq[p]),
      .req_addr (rreq_addr[p]),
      .arr_addr (arr_ra[p]),
      .arr_data (arr_rd[p]),
      .rsp_vld  (rsp_vld[p]),
      .rsp_data (rsp_data[p])
    );
  end

  lat_mem_core #(.AW(ADDR_W), .DW(DATA_W), .NP(NP)) u_core (
    .clk (clk),
    .rst (rst),
    .we  (arr_we),
    .wa  (arr_wa),
    .wd  (arr_wd),
    .ra  (arr_ra),
    .rd  (arr_rd)
  );

  assign rd_data    = rsp_data[0];
  assign rd_rsp_vld = rsp_vld[0];
  assign sh_rsp_vld = rsp_vld[1];

endmodule

// File: rtl/lat_mem_chk.sv
`timescale 1ns/1ps
module lat_mem_chk
  import lat_mem_pkg::*;
#(
  parameter int        ADDR_W     = 4,
  parameter int        DATA_W     = 8,
  parameter int        RD_LAT     = 2,
  parameter int        WR_LAT     = 2,
  parameter ruw_mode_e RUW        = RUW_WRITE_FIRST,
  parameter bit        HAS_SHARED = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_en,
  input logic              wr_mask,
  input logic              sh_en,
  input logic              sh_wmode,
  input logic [ADDR_W-1:0] sh_addr,
  input logic              sh_wmask,
  input logic [DATA_W-1:0] sh_rdata,
  input logic              rd_vld_int,
  input logic              sh_vld_int
);

  localparam int CMD_D = cmd_depth(RUW, RD_LAT);
  localparam int D_WR  = RD_LAT - CMD_D + WR_LAT;
  localparam int H     = RD_LAT + WR_LAT + 2;

  // Bit k of each *_all vector is the input value k cycles ago.
  logic [H:0]              r_en_all, s_en_all, w_all;
  logic [H-1:0]            r_en_q, s_en_q, w_q;
  logic [(H+1)*ADDR_W-1:0] r_ad_all, s_ad_all;
  logic [H*ADDR_W-1:0]     r_ad_q, s_ad_q;
  logic                    got_rd, got_sh;

  assign r_en_all = {r_en_q, rd_en & ~rst};
  assign s_en_all = {s_en_q, sh_en & ~sh_wmode & ~rst & HAS_SHARED};
  assign w_all    = {w_q, ~rst & ((wr_en & wr_mask) | (sh_en & sh_wmode & sh_wmask & HAS_SHARED))};
  assign r_ad_all = {r_ad_q, rd_addr};
  assign s_ad_all = {s_ad_q, sh_addr};

  always_ff @(posedge clk) begin
    if (rst) begin
      r_en_q <= '0;
      s_en_q <= '0;
      w_q    <= '0;
      r_ad_q <= '0;
      s_ad_q <= '0;
      got_rd <= 1'b0;
      got_sh <= 1'b0;
    end else begin
      r_en_q <= r_en_all[H-1:0];
      s_en_q <= s_en_all[H-1:0];
      w_q    <= w_all[H-1:0];
      r_ad_q <= r_ad_all[H*ADDR_W-1:0];
      s_ad_q <= s_ad_all[H*ADDR_W-1:0];
      got_rd <= got_rd | r_en_all[RD_LAT];
      got_sh <= got_sh | s_en_all[RD_LAT];
    end
  end

  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (rst)
    rd_vld_int == r_en_all[RD_LAT]); // R1

  AST_SH_RSP_TIMING: assert property (@(posedge clk) disable iff (rst)
    sh_vld_int == s_en_all[RD_LAT]); // R5

  AST_REREAD_SAME: assert property (@(posedge clk) disable iff (rst)
    (r_en_all[RD_LAT] && r_en_all[RD_LAT+1] && !w_all[D_WR] &&
     r_ad_all[RD_LAT*ADDR_W +: ADDR_W] == r_ad_all[(RD_LAT+1)*ADDR_W +: ADDR_W])
    |-> rd_data == $past(rd_data)); // R4

  if (HAS_SHARED) begin : g_agree
    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
      (r_en_all[RD_LAT] && s_en_all[RD_LAT] &&
       r_ad_all[RD_LAT*ADDR_W +: ADDR_W] == s_ad_all[RD_LAT*ADDR_W +: ADDR_W])
      |-> rd_data == sh_rdata); // R5
  end

  if (RUW == RUW_READ_FIRST && RD_LAT > 0) begin : g_hold
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
      (got_rd && !r_en_all[RD_LAT]) |-> $stable(rd_data)); // R6

    AST_SH_HOLD: assert property (@(posedge clk) disable iff (rst)
      (got_sh && !s_en_all[RD_LAT]) |-> $stable(sh_rdata)); // R6
  end

endmodule

bind lat_mem_wrap lat_mem_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT),
  .RUW(RUW), .HAS_SHARED(HAS_SHARED)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .wr_en      (wr_en),
  .wr_mask    (wr_mask),
  .sh_en      (sh_en),
  .sh_wmode   (sh_wmode),
  .sh_addr    (sh_addr),
  .sh_wmask   (sh_wmask),
  .sh_rdata   (sh_rdata),
  .rd_vld_int (rd_rsp_vld),
  .sh_vld_int (sh_rsp_vld)
);

// File: tb/lat_mem_wrap_bench.sv
`timescale 1ns/1ps
module lat_mem_wrap_bench;
  import lat_mem_pkg::*;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NC = 3;
  localparam int RING = 8;

  // Config 0: write-first RD=2 WR=3; 1: read-first RD=1 WR=2; 2: write-first RD=0 WR=1
  int RL [NC] = '{2, 1, 0};
  int WL [NC] = '{3, 2, 1};
  bit WF [NC] = '{1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          rd_en = 0, wr_en = 0, wr_mask = 0, sh_en = 0, sh_wmode = 0, sh_wmask = 0;
  logic [AW-1:0] rd_addr = 0, wr_addr = 0, sh_addr = 0;
  logic [DW-1:0] wr_data = 0, sh_wdata = 0;
  logic [DW-1:0] o_rd [NC];
  logic [DW-1:0] o_sh [NC];

  lat_mem_wrap #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(2), .WR_LAT(3),
                 .RUW(RUW_WRITE_FIRST), .HAS_SHARED(1'b1)) u_lat_mem_wrap (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(o_rd[0]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
    .sh_en(sh_en), .sh_wmode(sh_wmode), .sh_addr(sh_addr), .sh_wmask(sh_wmask),
    .sh_wdata(sh_wdata), .sh_rdata(o_sh[0]));

  lat_mem_wrap #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(1), .WR_LAT(2),
                 .RUW(RUW_READ_FIRST), .HAS_SHARED(1'b1)) u_lat_mem_wrap_rf (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(o_rd[1]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
    .sh_en(sh_en), .sh_wmode(sh_wmode), .sh_addr(sh_addr), .sh_wmask(sh_wmask),
    .sh_wdata(sh_wdata), .sh_rdata(o_sh[1]));

  lat_mem_wrap #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(0), .WR_LAT(1),
                 .RUW(RUW_WRITE_FIRST), .HAS_SHARED(1'b1)) u_lat_mem_wrap_z (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(o_rd[2]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
    .sh_en(sh_en), .sh_wmode(sh_wmode), .sh_addr(sh_addr), .sh_wmask(sh_wmask),
    .sh_wdata(sh_wdata), .sh_rdata(o_sh[2]));

  // Stimulus history ring
  logic          s_rst [RING], s_ren [RING], s_wen [RING], s_wm [RING];
  logic          s_sen [RING], s_smode [RING], s_smask [RING];
  logic [AW-1:0] s_ra [RING], s_wa [RING], s_sa [RING];
  logic [DW-1:0] s_wd [RING], s_sd [RING];

  logic [DW-1:0] mm    [NC][16];
  logic [DW-1:0] e_rd  [NC][RING];
  logic [DW-1:0] e_sh  [NC][RING];
  logic [DW-1:0] last_rd [NC];
  bit            have_last [NC];

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    done = 0;
  string dtag = "";

  // next-cycle stimulus
  logic          d_rst = 1, d_ren = 0, d_wen = 0, d_wm = 0, d_sen = 0, d_smode = 0, d_smask = 0;
  logic [AW-1:0] d_ra = 0, d_wa = 0, d_sa = 0;
  logic [DW-1:0] d_wd = 0, d_sd = 0;

  task automatic chk(string tag, int k, string port, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s%s cfg%0d %s cycle %0d: actual %h expected %h", tag, dtag, k, port, cyc, got, exp);
    end
  endtask

  task automatic clear_d();
    d_rst = 0; d_ren = 0; d_wen = 0; d_wm = 0; d_sen = 0; d_smode = 0; d_smask = 0;
  endtask

  task automatic step();
    int i;
    @(negedge clk);
    // writes that committed at the end of the previous cycle become visible now (R3, R8 order)
    for (int k = 0; k < NC; k++) begin
      int t = cyc - WL[k];
      if (t >= 0) begin
        int ti = t % RING;
        if (!s_rst[ti]) begin
          if (s_wen[ti] && s_wm[ti]) mm[k][s_wa[ti]] = s_wd[ti];
          if (s_sen[ti] && s_smode[ti] && s_smask[ti]) mm[k][s_sa[ti]] = s_sd[ti];
        end
      end
    end
    rst = d_rst; rd_en = d_ren; rd_addr = d_ra; wr_en = d_wen; wr_addr = d_wa;
    wr_data = d_wd; wr_mask = d_wm; sh_en = d_sen; sh_wmode = d_smode;
    sh_addr = d_sa; sh_wmask = d_smask; sh_wdata = d_sd;
    i = cyc % RING;
    s_rst[i] = d_rst; s_ren[i] = d_ren; s_ra[i] = d_ra; s_wen[i] = d_wen; s_wa[i] = d_wa;
    s_wd[i] = d_wd; s_wm[i] = d_wm; s_sen[i] = d_sen; s_smode[i] = d_smode;
    s_sa[i] = d_sa; s_smask[i] = d_smask; s_sd[i] = d_sd;
    for (int k = 0; k < NC; k++) begin
      e_rd[k][i] = mm[k][d_ra];
      e_sh[k][i] = mm[k][d_sa];
    end
    #1;
    for (int k = 0; k < NC; k++) begin
      int t = cyc - RL[k];
      string ct = (k == 2) ? "R7" : (WF[k] ? "R2" : "R1");
      if (t >= 0) begin
        int ti = t % RING;
        logic rv = s_ren[ti] && !s_rst[ti];
        logic sv = s_sen[ti] && !s_smode[ti] && !s_rst[ti];
        if (rv) begin
          chk(ct, k, "rd", o_rd[k], WF[k] ? mm[k][s_ra[ti]] : e_rd[k][ti]);
          if (!WF[k]) begin
            last_rd[k] = e_rd[k][ti];
            have_last[k] = 1;
          end
        end else if (k == 2 && !rst) begin
          chk("R7", k, "rd-idle", o_rd[k], mm[k][rd_addr]);
        end else if (!WF[k] && RL[k] > 0 && have_last[k]) begin
          chk("R6", k, "rd-hold", o_rd[k], last_rd[k]);
        end
        if (sv) chk("R5", k, "sh", o_sh[k], WF[k] ? mm[k][s_sa[ti]] : e_sh[k][ti]);
      end
    end
    cyc++;
  endtask

  task automatic idle(int n);
    clear_d();
    for (int j = 0; j < n; j++) step();
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic m);
    clear_d(); d_wen = 1; d_wa = a; d_wd = d; d_wm = m; step();
  endtask

  task automatic rd(logic [AW-1:0] a);
    clear_d(); d_ren = 1; d_ra = a; d_sen = 1; d_smode = 0; d_sa = a; step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < NC; k++) begin
      have_last[k] = 0;
      last_rd[k] = '0;
      for (int a = 0; a < 16; a++) mm[k][a] = '0;
    end
    for (int i = 0; i < RING; i++) begin
      s_rst[i] = 1; s_ren[i] = 0; s_wen[i] = 0; s_sen[i] = 0; s_wm[i] = 0;
      s_smode[i] = 0; s_smask[i] = 0; s_ra[i] = 0; s_wa[i] = 0; s_sa[i] = 0;
      s_wd[i] = 0; s_sd[i] = 0;
    end
    // reset
    clear_d(); d_rst = 1;
    repeat (3) step();
    // fill every word
    for (int a = 0; a < 16; a++) wr(a[AW-1:0], 8'(a * 7 + 3), 1'b1);
    idle(4);
    for (int a = 0; a < 16; a++) rd(a[AW-1:0]);
    idle(4);

    // R9: requests during reset are dropped
    dtag = "/R9";
    clear_d(); d_rst = 1; d_wen = 1; d_wa = 4'd5; d_wd = 8'hEE; d_wm = 1;
    d_sen = 1; d_smode = 1; d_sa = 4'd6; d_sd = 8'hDD; d_smask = 1;
    step();
    idle(4);
    rd(4'd5); rd(4'd6);
    idle(4);

    // R3: read-after-write two accesses apart, and back to back
    dtag = "/R3";
    wr(4'd6, 8'h20, 1'b1);
    wr(4'd14, 8'h57, 1'b1);
    idle(1);
    rd(4'd14);
    wr(4'd2, 8'h31, 1'b1);
    rd(4'd2);
    rd(4'd2);
    rd(4'd2);
    idle(4);

    // R4: masked write leaves word unchanged
    dtag = "/R4";
    wr(4'd9, 8'hAA, 1'b0);
    idle(4);
    rd(4'd9);
    rd(4'd9);
    idle(4);

    // R8: same-address collision, shared port wins
    dtag = "/R8";
    clear_d(); d_wen = 1; d_wa = 4'd3; d_wd = 8'h11; d_wm = 1;
    d_sen = 1; d_smode = 1; d_sa = 4'd3; d_sd = 8'h99; d_smask = 1;
    step();
    idle(4);
    rd(4'd3);
    idle(4);

    // random traffic
    dtag = "";
    for (int n = 0; n < 500; n++) begin
      clear_d();
      d_ren   = ($urandom % 2) == 0;
      d_ra    = AW'($urandom);
      d_wen   = ($urandom % 2) == 0;
      d_wa    = AW'($urandom % 8);
      d_wd    = DW'($urandom);
      d_wm    = ($urandom % 5) != 0;
      d_sen   = ($urandom % 5) < 3;
      d_smode = ($urandom % 2) == 0;
      d_sa    = AW'($urandom % 8);
      d_sd    = DW'($urandom);
      d_smask = ($urandom % 5) != 0;
      step();
    end
    idle(6);
    finish_run();
  end

endmodule